// File: doc/BRIEF.md
# Synchronous Message Transmit Sequencer

This block turns a chain of transmit buffer descriptors into a byte stream for a synchronous serial link. Each descriptor carries a ready flag, an interrupt flag, a last flag, a CRC-append flag, an abut flag and a byte count. The data bytes come in on a separate byte port. The block hands one byte to the serial shifter on each cycle where the shifter strobes `tx_take`. It keeps a running CRC16 over the data and appends it wherever a buffer asks for it. Between messages it sends sync character pairs or an idle fill.

When a buffer completes or is aborted, the block pulses a write-back with status bits. A write-back always means that the descriptor's ready flag is to be cleared. It can also raise a transmit event or an error event. Two things abort a message: the data port running dry while a byte is due, or clear-to-send dropping while the message is on the line. An aborted message is followed by all-ones idle.

States:
- `ST_FILL`: inter-message fill.
- `ST_DATA`: buffer data.
- `ST_CRC_LO`: CRC low byte.
- `ST_CRC_HI`: CRC high byte.
- `ST_SYNC`: the counted sync pairs after a message.

Transitions:
- FILL→DATA when a ready descriptor is accepted.
- DATA→CRC_LO on the final byte of a buffer with the CRC flag set.
- CRC_LO→CRC_HI on the next take.
- DATA or CRC_HI→DATA when the next buffer is chained.
- DATA or CRC_HI→SYNC at a message end with a non-zero pair count.
- DATA or CRC_HI→FILL at a message end with a zero pair count, or when no chained buffer is present.
- SYNC→FILL after the last sync byte.
- DATA, CRC_LO or CRC_HI→FILL on an abort.

Top module: `syncmsg_tx`

## Requirements
- R1: After reset the state is ST_FILL with the fill phase at its start. With `cfg_fill_sync`=1, `tx_byte` shows `cfg_syn1`. `desc_ready` and `wb_valid` are low.
- R2: In ST_FILL the fill depends on `cfg_fill_sync`. When it is 1, the fill alternates `cfg_syn1`, `cfg_syn2`, starting with `cfg_syn1` each time the state is entered, and advances only on takes. When it is 0, the fill is 8'hFF.
- R3: A descriptor is accepted (`desc_ready`=1) only when `desc_valid` and `desc_rdy` are both high. This happens on a take in ST_FILL, or on the take that ends a buffer that may chain. Data bytes go out in order, one per take, and nothing advances on cycles without a take. Byte counts must be at least 1.
- R4: The CRC is sent whenever a buffer has its CRC flag set, whatever the state of its last flag. It is sent low byte first, right after the buffer's final data byte. After a non-last buffer, the next ready buffer's data follows the CRC directly.
- R5: The CRC16 is computed least-significant-bit first with the reflected polynomial 16'hA001 (x^16+x^15+x^2+1), with no final inversion. It starts from `cfg_crc_preset`. It covers every data byte sent since the last CRC insertion or abort, across buffers sent without CRC. It restarts after each insertion and after each abort.
- R6: At the end of a message (last flag set, not chained), exactly 2×`cfg_sync_pairs` bytes follow, as alternating `cfg_syn1`,`cfg_syn2` pairs, and then the fill. A count of 0 goes straight to the fill.
- R7: If a last buffer has its abut flag set and the next descriptor is valid and ready, the next message's data follows with no sync or fill. If the next descriptor is not ready, the R6 behaviour applies.
- R8: `wb_valid` pulses for one cycle, in the cycle after the take of a buffer's final byte. That final byte is its final data byte, or its CRC high byte. The status is {`wb_underrun`,`wb_cts_lost`,`ev_tx`,`ev_txe`}. `ev_tx` is set only when the buffer's interrupt flag is set and there was no error; with the flag clear, no event is raised.
- R9: A take in ST_DATA with `data_valid` low, while `cts` is high, is an underrun. The block sends 8'hFF for that take and aborts. On the next cycle it writes back with `wb_underrun`=1, and `ev_txe`=1 if the interrupt flag is set. It then sends 8'hFF fill until the next descriptor has been accepted, whatever `cfg_fill_sync` says.
- R10: `cts` low in ST_DATA, ST_CRC_LO or ST_CRC_HI aborts the message. The block shows 8'hFF in that cycle. On the next cycle it writes back with `wb_cts_lost`=1 and `wb_underrun`=0, then sends all-ones fill as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_crc_preset | input | 16 | CRC16 start value (all zeros or all ones) |
| cfg_syn1 | input | 8 | First sync character |
| cfg_syn2 | input | 8 | Second sync character |
| cfg_sync_pairs | input | PAIR_W | Number of sync pairs after each message |
| cfg_fill_sync | input | 1 | Fill select: 1 = sync pairs, 0 = all ones |
| desc_valid | input | 1 | A descriptor is presented |
| desc_ready | output | 1 | Descriptor accepted this cycle |
| desc_rdy | input | 1 | Descriptor ready flag |
| desc_int | input | 1 | Descriptor interrupt flag |
| desc_last | input | 1 | Descriptor last-of-message flag |
| desc_crc | input | 1 | Append CRC after this buffer |
| desc_abut | input | 1 | Chain the next ready message directly |
| desc_len | input | LEN_W | Byte count (at least 1) |
| data_valid | input | 1 | A data byte is available |
| data_byte | input | 8 | Data byte |
| data_ready | output | 1 | Data byte consumed this cycle |
| cts | input | 1 | Clear-to-send |
| tx_take | input | 1 | Shifter takes `tx_byte` this cycle |
| tx_byte | output | 8 | Byte offered to the shifter |
| wb_valid | output | 1 | Descriptor write-back pulse |
| wb_underrun | output | 1 | Write-back status: underrun |
| wb_cts_lost | output | 1 | Write-back status: clear-to-send lost |
| ev_tx | output | 1 | Transmit-done event |
| ev_txe | output | 1 | Transmit-error event |

## Verification
The hardest case to reach is a CRC that covers more than one buffer. That needs several messages without CRC, sent after an earlier insertion and with a preset change in between, followed by a buffer that does carry the CRC. The bench builds this by running the abut and sync scenarios without CRC and only then sending a buffer with CRC. Its behavioural model computes the expected CRC over the whole span of bytes since the last insertion. Aborts are reached in a similar way: a message is started with fewer data bytes queued than its count, or the bench pulls clear-to-send low once the model's expected queue shows the message is partly sent. In both cases the model then expects all-ones fill, even in sync-fill mode.

// File: rtl/syncmsg_pkg.sv
package syncmsg_pkg;
    typedef enum logic [2:0] {
        ST_FILL,
        ST_DATA,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_SYNC
    } txst_e;

    typedef struct packed {
        logic intr;
        logic last;
        logic crc;
        logic abut;
    } bdflags_t;

    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;
    localparam logic [7:0]  IDLE_ONES     = 8'hFF;
endpackage

// File: rtl/syncmsg_crc16.sv
module syncmsg_crc16
    import syncmsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] preset,
    input  logic        restart,
    input  logic        advance,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] acc_q;
    logic        fresh_q;
    logic [15:0] base;
    logic [15:0] nxt;

    // A fresh accumulator reads the preset input directly.
    assign base = fresh_q ? preset : acc_q;
    assign crc  = base;

    always_comb begin
        nxt = base ^ {8'h00, din};
        for (int k = 0; k < 8; k++) begin
            nxt = nxt[0] ? ((nxt >> 1) ^ CRC_POLY_REFL) : (nxt >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            fresh_q <= 1'b1;
        end else if (restart) begin
            fresh_q <= 1'b1;
        end else if (advance) begin
            acc_q   <= nxt;
            fresh_q <= 1'b0;
        end
    end

    assert_restart_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (crc == preset));
endmodule

// File: rtl/syncmsg_fill.sv
module syncmsg_fill
    import syncmsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       take,
    input  logic       ones,
    input  logic [7:0] syn1,
    input  logic [7:0] syn2,
    output logic [7:0] fill_byte
);
    logic ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= 1'b0;
        end else if (!active) begin
            ph_q <= 1'b0;
        end else if (take) begin
            ph_q <= !ph_q;
        end
    end

    assign fill_byte = ones ? IDLE_ONES : (ph_q ? syn2 : syn1);

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !take) |=> (ph_q == $past(ph_q)));
endmodule

// File: rtl/syncmsg_tx.sv
module syncmsg_tx
    import syncmsg_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int PAIR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cfg_crc_preset,
    input  logic [7:0]        cfg_syn1,
    input  logic [7:0]        cfg_syn2,
    input  logic [PAIR_W-1:0] cfg_sync_pairs,
    input  logic              cfg_fill_sync,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic              desc_rdy,
    input  logic              desc_int,
    input  logic              desc_last,
    input  logic              desc_crc,
    input  logic              desc_abut,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    output logic              data_ready,
    input  logic              cts,
    input  logic              tx_take,
    output logic [7:0]        tx_byte,
    output logic              wb_valid,
    output logic              wb_underrun,
    output logic              wb_cts_lost,
    output logic              ev_tx,
    output logic              ev_txe
);
    localparam int SYNC_W = PAIR_W + 1;

    txst_e             st_q, st_d, end_target;
    bdflags_t          fl_q;
    logic [LEN_W-1:0]  left_q;
    logic [SYNC_W-1:0] sync_left_q;
    logic              ones_q;
    logic              in_msg, cts_drop, dry, abort, data_ok, final_byte;
    logic              crc_hi_ok, buf_end, next_ok, chain, load_desc;
    logic              fill_active, fill_ones;
    logic [15:0]       crc_val;
    logic [7:0]        fill_val;

    assign in_msg     = (st_q == ST_DATA) || (st_q == ST_CRC_LO) || (st_q == ST_CRC_HI);
    assign cts_drop   = in_msg && !cts;
    assign dry        = (st_q == ST_DATA) && cts && tx_take && !data_valid;
    assign abort      = cts_drop || dry;
    assign data_ok    = (st_q == ST_DATA) && cts && tx_take && data_valid;
    assign final_byte = (left_q == LEN_W'(1));
    assign crc_hi_ok  = (st_q == ST_CRC_HI) && cts && tx_take;
    assign buf_end    = (data_ok && final_byte && !fl_q.crc) || crc_hi_ok;
    assign next_ok    = desc_valid && desc_rdy;
    assign chain      = next_ok && (!fl_q.last || fl_q.abut);
    assign load_desc  = ((st_q == ST_FILL) && tx_take && next_ok) || (buf_end && chain);

    assign desc_ready = load_desc;
    assign data_ready = data_ok;

    assign fill_active = (st_q == ST_FILL) || (st_q == ST_SYNC);
    assign fill_ones   = (st_q == ST_FILL) && (ones_q || !cfg_fill_sync);

    syncmsg_crc16 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (cfg_crc_preset),
        .restart (abort || crc_hi_ok),
        .advance (data_ok),
        .din     (data_byte),
        .crc     (crc_val)
    );

    syncmsg_fill u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (fill_active),
        .take      (tx_take),
        .ones      (fill_ones),
        .syn1      (cfg_syn1),
        .syn2      (cfg_syn2),
        .fill_byte (fill_val)
    );

    // Where a finished buffer leads.
    always_comb begin
        if (chain) begin
            end_target = ST_DATA;
        end else if (fl_q.last && (cfg_sync_pairs != '0)) begin
            end_target = ST_SYNC;
        end else begin
            end_target = ST_FILL;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FILL:   if (load_desc) st_d = ST_DATA;
            ST_SYNC:   if (tx_take && (sync_left_q == SYNC_W'(1))) st_d = ST_FILL;
            ST_DATA: begin
                if (abort) begin
                    st_d = ST_FILL;
                end else if (data_ok && final_byte) begin
                    st_d = fl_q.crc ? ST_CRC_LO : end_target;
                end
            end
            ST_CRC_LO: begin
                if (abort)        st_d = ST_FILL;
                else if (tx_take) st_d = ST_CRC_HI;
            end
            ST_CRC_HI: begin
                if (abort)        st_d = ST_FILL;
                else if (tx_take) st_d = end_target;
            end
            default:              st_d = ST_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_FILL;
        else        st_q <= st_d;
    end

    // Descriptor context and counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q        <= '0;
            left_q      <= '0;
            sync_left_q <= '0;
            ones_q      <= 1'b0;
        end else begin
            if (load_desc) begin
                fl_q   <= '{intr: desc_int, last: desc_last, crc: desc_crc, abut: desc_abut};
                left_q <= desc_len;
            end else if (data_ok) begin
                left_q <= left_q - LEN_W'(1);
            end
            if ((st_d == ST_SYNC) && (st_q != ST_SYNC)) begin
                sync_left_q <= {cfg_sync_pairs, 1'b0};
            end else if ((st_q == ST_SYNC) && tx_take) begin
                sync_left_q <= sync_left_q - SYNC_W'(1);
            end
            if (abort)          ones_q <= 1'b1;
            else if (load_desc) ones_q <= 1'b0;
        end
    end

    // Write-back and event outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_valid    <= 1'b0;
            wb_underrun <= 1'b0;
            wb_cts_lost <= 1'b0;
            ev_tx       <= 1'b0;
            ev_txe      <= 1'b0;
        end else begin
            wb_valid    <= abort || buf_end;
            wb_underrun <= dry;
            wb_cts_lost <= cts_drop;
            ev_tx       <= fl_q.intr && buf_end;
            ev_txe      <= fl_q.intr && abort;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_DATA:   tx_byte = (cts && data_valid) ? data_byte : IDLE_ONES;
            ST_CRC_LO: tx_byte = cts ? crc_val[7:0]  : IDLE_ONES;
            ST_CRC_HI: tx_byte = cts ? crc_val[15:8] : IDLE_ONES;
            default:   tx_byte = fill_val;
        endcase
    end

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DATA) && !tx_take && cts) |=> ((st_q == ST_DATA) && (left_q == $past(left_q))));
    assert_crc_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_CRC_LO) && tx_take && cts) |=> (st_q == ST_CRC_HI));
    assert_sync_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SYNC) |-> (sync_left_q != '0));
    assert_event_has_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx || ev_txe) |-> wb_valid);
    assert_underrun_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DATA) && cts && tx_take && !data_valid) |=> (wb_valid && wb_underrun && (st_q == ST_FILL)));
    assert_cts_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_msg && !cts) |=> (wb_valid && wb_cts_lost && !wb_underrun));
endmodule

// File: tb/tb_syncmsg_tx.sv
module tb_syncmsg_tx;
    localparam int LW = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [15:0]   cfg_crc_preset;
    logic [7:0]    cfg_syn1, cfg_syn2;
    logic [PW-1:0] cfg_sync_pairs;
    logic          cfg_fill_sync;
    logic          desc_valid, desc_ready, desc_rdy, desc_int, desc_last, desc_crc, desc_abut;
    logic [LW-1:0] desc_len;
    logic          data_valid, data_ready;
    logic [7:0]    data_byte;
    logic          cts, tx_take;
    logic [7:0]    tx_byte;
    logic          wb_valid, wb_underrun, wb_cts_lost, ev_tx, ev_txe;

    always #5 clk = ~clk;

    syncmsg_tx #(.LEN_W(LW), .PAIR_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_crc_preset(cfg_crc_preset), .cfg_syn1(cfg_syn1),
        .cfg_syn2(cfg_syn2), .cfg_sync_pairs(cfg_sync_pairs), .cfg_fill_sync(cfg_fill_sync),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_rdy(desc_rdy), .desc_int(desc_int),
        .desc_last(desc_last), .desc_crc(desc_crc), .desc_abut(desc_abut), .desc_len(desc_len),
        .data_valid(data_valid), .data_byte(data_byte), .data_ready(data_ready), .cts(cts),
        .tx_take(tx_take), .tx_byte(tx_byte), .wb_valid(wb_valid), .wb_underrun(wb_underrun),
        .wb_cts_lost(wb_cts_lost), .ev_tx(ev_tx), .ev_txe(ev_txe)
    );

    typedef struct {
        bit rdy; bit intr; bit last; bit crc; bit abut; int len;
    } bd_t;

    bd_t dq[$];
    int  bq[$];
    int  eq[$];
    int  wq[$];
    int  total = 0;
    int  bad = 0;
    bit  ph = 1'b0;
    bit  forced = 1'b0;
    bit  gaps = 1'b0;
    bit  cts_v = 1'b1;
    int  cyc = 0;

    function automatic logic [15:0] crc_of(logic [15:0] init, int b[$]);
        logic [15:0] c;
        c = init;
        foreach (b[i]) begin
            c = c ^ 16'(b[i] & 255);
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic add_bytes(int s[$]);
        foreach (s[i]) bq.push_back(s[i]);
    endtask

    task automatic expect_bytes(int s[$]);
        foreach (s[i]) eq.push_back(s[i]);
    endtask

    task automatic step(string rq);
        logic [7:0] want;
        int e;
        desc_valid = (dq.size() > 0);
        if (desc_valid) begin
            desc_rdy  = dq[0].rdy;  desc_int  = dq[0].intr; desc_last = dq[0].last;
            desc_crc  = dq[0].crc;  desc_abut = dq[0].abut; desc_len  = LW'(dq[0].len);
        end else begin
            desc_rdy = 1'b0; desc_int = 1'b0; desc_last = 1'b0;
            desc_crc = 1'b0; desc_abut = 1'b0; desc_len = '0;
        end
        data_valid = (bq.size() > 0);
        data_byte  = data_valid ? 8'(bq[0]) : 8'h00;
        cts        = cts_v;
        tx_take    = gaps ? cyc[0] : 1'b1;
        #1;
        if (tx_take) begin
            e = (eq.size() > 0) ? eq.pop_front() : -1;
            if (e < 0) begin
                want = (cfg_fill_sync && !forced) ? (ph ? cfg_syn2 : cfg_syn1) : 8'hFF;
                ph = !ph;
            end else begin
                want = 8'(e);
                ph = 1'b0;
            end
            chk(rq, tx_byte, want);
        end
        if (desc_ready) begin
            void'(dq.pop_front());
            forced = 1'b0;
        end
        if (data_ready) void'(bq.pop_front());
        @(posedge clk);
        #1;
        if (wb_valid) begin
            if (wq.size() == 0) chk({rq, " unexpected writeback"}, 1, 0);
            else chk({rq, " writeback status"}, {wb_underrun, wb_cts_lost, ev_tx, ev_txe}, wq.pop_front());
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic drain(string rq, int extra);
        int guard;
        guard = 0;
        while (eq.size() > 0 && guard < 500) begin
            step(rq);
            guard++;
        end
        repeat (extra) step(rq);
        chk({rq, " all writebacks seen"}, wq.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] c;
        int s[$];
        rst_n = 1'b0;
        cfg_crc_preset = 16'hFFFF; cfg_syn1 = 8'h16; cfg_syn2 = 8'h96;
        cfg_sync_pairs = PW'(2); cfg_fill_sync = 1'b1;
        desc_valid = 1'b0; desc_rdy = 1'b0; desc_int = 1'b0; desc_last = 1'b0;
        desc_crc = 1'b0; desc_abut = 1'b0; desc_len = '0;
        data_valid = 1'b0; data_byte = 8'h00; cts = 1'b1; tx_take = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset fill byte", tx_byte, 8'h16);
        chk("R1 reset no accept", desc_ready, 0);
        chk("R1 reset no writeback", wb_valid, 0);
        @(negedge clk);

        // R2: both fill patterns
        repeat (5) step("R2 sync-pair fill");
        cfg_fill_sync = 1'b0;
        repeat (3) step("R2 all-ones fill");

        // R4 R5 R6 R8: header buffer with CRC, body with CRC, two sync pairs
        dq.push_back('{1, 1, 0, 1, 0, 2}); add_bytes({'h11, 'h22});
        dq.push_back('{1, 0, 1, 1, 0, 3}); add_bytes({'h33, 'h44, 'h55});
        s = {'h11, 'h22}; c = crc_of(16'hFFFF, s);
        expect_bytes({-1, 'h11, 'h22, int'(c[7:0]), int'(c[15:8])});
        s = {'h33, 'h44, 'h55}; c = crc_of(16'hFFFF, s);
        expect_bytes({'h33, 'h44, 'h55, int'(c[7:0]), int'(c[15:8]), 'h16, 'h96, 'h16, 'h96});
        wq.push_back(4'b0010); wq.push_back(4'b0000);
        drain("R4 R5 R6 R8 header and body", 3);

        // R4 R5 R6: buffer without CRC, CRC spans into next message, zero pairs
        cfg_crc_preset = 16'h0000; cfg_sync_pairs = '0;
        dq.push_back('{1, 0, 1, 0, 0, 2}); add_bytes({'hA1, 'hA2});
        dq.push_back('{1, 1, 1, 1, 0, 1}); add_bytes({'hB1});
        s = {'hA1, 'hA2, 'hB1}; c = crc_of(16'h0000, s);
        expect_bytes({-1, 'hA1, 'hA2, -1, 'hB1, int'(c[7:0]), int'(c[15:8])});
        wq.push_back(4'b0000); wq.push_back(4'b0010);
        drain("R4 R5 R6 R8 no-crc buffer and span", 3);

        // R7: abut chained, then abut with next not ready
        cfg_crc_preset = 16'hFFFF; cfg_sync_pairs = PW'(2);
        dq.push_back('{1, 0, 1, 0, 1, 2}); add_bytes({'hC1, 'hC2});
        dq.push_back('{1, 0, 1, 0, 0, 2}); add_bytes({'hD1, 'hD2});
        expect_bytes({-1, 'hC1, 'hC2, 'hD1, 'hD2, 'h16, 'h96, 'h16, 'h96});
        wq.push_back(4'b0000); wq.push_back(4'b0000);
        drain("R7 abut chained", 2);
        dq.push_back('{1, 0, 1, 0, 1, 1}); add_bytes({'hE1});
        dq.push_back('{0, 0, 1, 0, 0, 1});
        expect_bytes({-1, 'hE1, 'h16, 'h96, 'h16, 'h96});
        wq.push_back(4'b0000);
        drain("R7 abut next not ready", 3);
        dq.delete();

        // R3 R5: take gaps; CRC covers every byte since the last insertion
        gaps = 1'b1;
        dq.push_back('{1, 1, 1, 1, 0, 3}); add_bytes({'h5A, 'h5B, 'h5C});
        s = {'hC1, 'hC2, 'hD1, 'hD2, 'hE1, 'h5A, 'h5B, 'h5C}; c = crc_of(16'hFFFF, s);
        expect_bytes({-1, 'h5A, 'h5B, 'h5C, int'(c[7:0]), int'(c[15:8]), 'h16, 'h96, 'h16, 'h96});
        wq.push_back(4'b0010);
        drain("R3 R5 take gaps", 4);
        gaps = 1'b0;

        // R9: underrun in sync-fill mode, then forced all-ones fill
        cfg_fill_sync = 1'b1;
        dq.push_back('{1, 1, 1, 0, 0, 4}); add_bytes({'h61, 'h62});
        expect_bytes({-1, 'h61, 'h62, 'hFF});
        wq.push_back(4'b1001);
        drain("R9 underrun", 0);
        forced = 1'b1;
        drain("R9 all-ones after abort", 4);

        // R10: clear-to-send drop mid-message
        dq.push_back('{1, 1, 1, 1, 0, 5}); add_bytes({'h71, 'h72, 'h73, 'h74, 'h75});
        expect_bytes({-1, 'h71, 'h72});
        drain("R10 message start", 0);
        cts_v = 1'b0;
        eq.push_back('hFF);
        wq.push_back(4'b0101);
        step("R10 cts drop");
        cts_v = 1'b1;
        forced = 1'b1;
        bq.delete();
        drain("R10 all-ones after abort", 3);

        // R5: CRC restarts from the preset after an abort
        cfg_fill_sync = 1'b0; cfg_sync_pairs = '0;
        dq.push_back('{1, 0, 1, 1, 0, 1}); add_bytes({'h81});
        s = {'h81}; c = crc_of(16'hFFFF, s);
        expect_bytes({-1, 'h81, int'(c[7:0]), int'(c[15:8])});
        wq.push_back(4'b0000);
        drain("R5 crc restart after abort", 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule